// File: doc/BRIEF.md
# Ternary Rule Table with Block Gating and Range Clear

This block is a ternary classification table of `NUM_BLOCKS` blocks with `BLOCK_ENTRIES` rules in each. Every rule holds six 32-bit template words, a 24-bit fixed-field word, a mask for each of these, and a 5-bit condition word whose top flag marks the rule as valid. A lookup presents a key made of six template words and one fixed-field word. A rule matches when the key equals the rule data in every bit position where the rule mask is 1. Among valid matching rules whose block is enabled, the one with the lowest index is reported one cycle later.

Software writes and reads rules and two control words through a register port. The first control word is a per-block lookup-enable bitmap. The second is a range-clear command. When its execute flag is written as 1, a hardware engine invalidates one rule per clock across an inclusive index range. The execute flag reads back as 1 until the last rule in the range has been invalidated. While a clear is running, rules that are still waiting to be cleared cannot hit.

The rule index width is log2 of the total entry count. That total must be a power of two and no larger than 2048.

Top module: `rule_tcam`

## Requirements
- R1: After reset, `hit_valid` and `hit` are 0, and the enable bitmap (control word 0) and the clear command word (control word 1) both read back as 0.
- R2: A rule matches when `((key ^ data) & mask) == 0` holds for all six template words and for the 24-bit fixed word. The fixed word carries the template id in bits [1:0]. Key bits under a mask bit of 0 have no effect on the result.
- R3: A rule takes part in lookups only when bit 31 of its condition word is 1. Condition bits 31..27 are stored and read back in place, and bits 26..0 read as 0.
- R4: Rule `i` belongs to block `i / BLOCK_ENTRIES`. If bit `b` of control word 0 is 0, no rule in block `b` hits.
- R5: When several eligible rules match, `hit_idx` is the lowest of their indices.
- R6: `hit_valid` is 1 exactly one cycle after a cycle with `key_valid` high. `hit` and `hit_idx` are valid in that same cycle, and `hit` is 0 whenever `hit_valid` is 0.
- R7: Writing control word 1 with bit 0 set starts a clear. The start index comes from bits [IDX_W:1] and the end index from bits [11+IDX_W:12]. The clear invalidates every rule from start to end inclusive and leaves all other rules unchanged.
- R8: The clear invalidates one rule per clock. For a range of N rules, bit 0 of control word 1 reads as 1 for the N cycles after the command and as 0 after that.
- R9: While a clear is running, a rule whose index lies between the current clear position and the end index does not hit, even if it is still valid.
- R10: A clear command is ignored if its start index is greater than its end index, or if another clear is already running.
- R11: Entry words read back as written. Word selects 0..5 are the data words, 6 is the fixed data (zero-extended), 7..12 are the template masks, 13 is the fixed mask and 14 is the condition word. Reads return data one cycle after `cfg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_ctl | input | 1 | 1 selects the control words, 0 selects rule words |
| cfg_idx | input | IDX_W | Rule index for rule word access |
| cfg_word | input | 4 | Word select (rule word 0..14, or control word 0..1) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| key_valid | input | 1 | Lookup request |
| key_words | input | 192 | Six template key words; word k is at bits [32k+31:32k] |
| key_fixed | input | 24 | Fixed-field key word |
| hit_valid | output | 1 | Lookup result strobe |
| hit | output | 1 | A rule matched |
| hit_idx | output | IDX_W | Index of the winning rule |

## Verification
The assertions check the following on every cycle:
- the one-cycle lookup handshake;
- that a reported hit always lies in a block that was enabled, belongs to a rule that was valid, and lies outside the active clear window;
- that the clear engine advances by exactly one rule per cycle;
- that the end rule is invalid when the engine stops.

The lowest-index priority, the ternary don't-care behaviour and the exact readback timing of the execute flag can only be shown by the bench. It compares lookups against a software model of the table and runs directed clears: one of an eleven-rule range, one of the whole table overlapped with a lookup, one with a reversed range, and one issued while another clear is busy.

// File: rtl/rule_tcam_pkg.sv
package rule_tcam_pkg;
  localparam int WORD_W   = 32;
  localparam int N_TWORDS = 6;
  localparam int FIX_W    = 24;
  localparam int COND_W   = 5;
  localparam int WSEL_W   = 4;
  // rule word selects
  localparam int WSEL_DAT0  = 0;
  localparam int WSEL_FIXD  = 6;
  localparam int WSEL_MSK0  = 7;
  localparam int WSEL_FIXM  = 13;
  localparam int WSEL_COND  = 14;
  // control word selects
  localparam int CSEL_EN    = 0;
  localparam int CSEL_CLR   = 1;
  // clear command field positions
  localparam int CLR_START_LSB = 1;
  localparam int CLR_END_LSB   = 12;
  localparam int KEY_W = N_TWORDS * WORD_W;
endpackage

// File: rtl/rt_entry_cmp.sv
module rt_entry_cmp
  import rule_tcam_pkg::*;
(
  input  logic [KEY_W-1:0] key_t,
  input  logic [FIX_W-1:0] key_f,
  input  logic [KEY_W-1:0] dat_t,
  input  logic [KEY_W-1:0] msk_t,
  input  logic [FIX_W-1:0] dat_f,
  input  logic [FIX_W-1:0] msk_f,
  output logic             match
);
  always_comb begin
    match = (((key_t ^ dat_t) & msk_t) == '0) && (((key_f ^ dat_f) & msk_f) == '0);
  end
endmodule

// File: rtl/rt_prio_enc.sv
module rt_prio_enc #(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rt_clear_engine.sv
module rt_clear_engine #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [IW-1:0] start_idx,
  input  logic [IW-1:0] end_idx,
  output logic          busy,
  output logic [IW-1:0] cur,
  output logic [IW-1:0] last
);
  logic          busy_q, busy_d;
  logic [IW-1:0] cur_q, cur_d, last_q, last_d;

  always_comb begin
    busy_d = busy_q;
    cur_d  = cur_q;
    last_d = last_q;
    if (busy_q) begin
      if (cur_q == last_q) busy_d = 1'b0;
      else                 cur_d  = cur_q + IW'(1);
    end else if (go && (start_idx <= end_idx)) begin
      busy_d = 1'b1;
      cur_d  = start_idx;
      last_d = end_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      last_q <= '0;
    end else begin
      busy_q <= busy_d;
      cur_q  <= cur_d;
      last_q <= last_d;
    end
  end

  assign busy = busy_q;
  assign cur  = cur_q;
  assign last = last_q;
endmodule

// File: rtl/rule_tcam.sv
module rule_tcam
  import rule_tcam_pkg::*;
#(
  parameter int NUM_BLOCKS    = 4,
  parameter int BLOCK_ENTRIES = 16,
  localparam int N_ENT = NUM_BLOCKS * BLOCK_ENTRIES,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic              cfg_ctl,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [WSEL_W-1:0] cfg_word,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              key_valid,
  input  logic [KEY_W-1:0]  key_words,
  input  logic [FIX_W-1:0]  key_fixed,
  output logic              hit_valid,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  // rule storage: data and masks carry no reset, only condition flags do
  logic [KEY_W-1:0]  tdat_q [N_ENT];
  logic [KEY_W-1:0]  tmsk_q [N_ENT];
  logic [FIX_W-1:0]  fdat_q [N_ENT];
  logic [FIX_W-1:0]  fmsk_q [N_ENT];
  logic [COND_W-1:0] cond_q [N_ENT];
  logic [NUM_BLOCKS-1:0] lkup_en_q;
  logic [N_ENT-1:0]  vld, elig;
  logic              ent_we, en_we, clr_we;
  logic              clr_busy;
  logic [IDX_W-1:0]  clr_cur, clr_end;
  logic              found;
  logic [IDX_W-1:0]  found_idx;
  logic [31:0]       rd_mux;
  logic              hit_valid_q, hit_q;
  logic [IDX_W-1:0]  hit_idx_q;

  assign ent_we = cfg_we && !cfg_ctl;
  assign en_we  = cfg_we && cfg_ctl && (cfg_word == WSEL_W'(CSEL_EN));
  assign clr_we = cfg_we && cfg_ctl && (cfg_word == WSEL_W'(CSEL_CLR)) && cfg_wdata[0];

  rt_clear_engine #(.IW(IDX_W)) u_clr (
    .clk(clk), .rst_n(rst_n), .go(clr_we),
    .start_idx(cfg_wdata[CLR_START_LSB +: IDX_W]),
    .end_idx(cfg_wdata[CLR_END_LSB +: IDX_W]),
    .busy(clr_busy), .cur(clr_cur), .last(clr_end)
  );

  always_ff @(posedge clk) begin
    if (ent_we) begin
      for (int k = 0; k < N_TWORDS; k++) begin
        if (cfg_word == WSEL_W'(WSEL_DAT0 + k)) tdat_q[cfg_idx][k*WORD_W +: WORD_W] <= cfg_wdata;
        if (cfg_word == WSEL_W'(WSEL_MSK0 + k)) tmsk_q[cfg_idx][k*WORD_W +: WORD_W] <= cfg_wdata;
      end
      if (cfg_word == WSEL_W'(WSEL_FIXD)) fdat_q[cfg_idx] <= cfg_wdata[FIX_W-1:0];
      if (cfg_word == WSEL_W'(WSEL_FIXM)) fmsk_q[cfg_idx] <= cfg_wdata[FIX_W-1:0];
    end
  end

  // condition flags; the clear engine wins over a same-cycle write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) cond_q[e] <= '0;
    end else begin
      if (ent_we && (cfg_word == WSEL_W'(WSEL_COND))) cond_q[cfg_idx] <= cfg_wdata[31 -: COND_W];
      if (clr_busy) cond_q[clr_cur] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lkup_en_q <= '0;
    else if (en_we) lkup_en_q <= cfg_wdata[NUM_BLOCKS-1:0];
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic m;
    rt_entry_cmp u_cmp (
      .key_t(key_words), .key_f(key_fixed),
      .dat_t(tdat_q[e]), .msk_t(tmsk_q[e]),
      .dat_f(fdat_q[e]), .msk_f(fmsk_q[e]),
      .match(m)
    );
    assign vld[e]  = cond_q[e][COND_W-1];
    assign elig[e] = vld[e] && lkup_en_q[e / BLOCK_ENTRIES] && m &&
                     !(clr_busy && (IDX_W'(e) >= clr_cur) && (IDX_W'(e) <= clr_end));
  end

  rt_prio_enc #(.N(N_ENT)) u_prio (.req(elig), .found(found), .idx(found_idx));

  always_comb begin
    rd_mux = '0;
    if (cfg_ctl) begin
      if (cfg_word == WSEL_W'(CSEL_EN)) rd_mux[NUM_BLOCKS-1:0] = lkup_en_q;
      if (cfg_word == WSEL_W'(CSEL_CLR)) begin
        rd_mux[0]                      = clr_busy;
        rd_mux[CLR_START_LSB +: IDX_W] = clr_cur;
        rd_mux[CLR_END_LSB +: IDX_W]   = clr_end;
      end
    end else begin
      for (int k = 0; k < N_TWORDS; k++) begin
        if (cfg_word == WSEL_W'(WSEL_DAT0 + k)) rd_mux = tdat_q[cfg_idx][k*WORD_W +: WORD_W];
        if (cfg_word == WSEL_W'(WSEL_MSK0 + k)) rd_mux = tmsk_q[cfg_idx][k*WORD_W +: WORD_W];
      end
      if (cfg_word == WSEL_W'(WSEL_FIXD)) rd_mux = 32'(fdat_q[cfg_idx]);
      if (cfg_word == WSEL_W'(WSEL_FIXM)) rd_mux = 32'(fmsk_q[cfg_idx]);
      if (cfg_word == WSEL_W'(WSEL_COND)) rd_mux = {cond_q[cfg_idx], {(32-COND_W){1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_rdata <= '0;
    else if (cfg_re) cfg_rdata <= rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid_q <= 1'b0;
      hit_q       <= 1'b0;
      hit_idx_q   <= '0;
    end else begin
      hit_valid_q <= key_valid;
      hit_q       <= key_valid && found;
      if (key_valid) hit_idx_q <= found_idx;
    end
  end

  assign hit_valid = hit_valid_q;
  assign hit       = hit_q;
  assign hit_idx   = hit_idx_q;
endmodule

// File: rtl/rule_tcam_chk.sv
module rule_tcam_chk #(
  parameter int NUM_BLOCKS    = 4,
  parameter int BLOCK_ENTRIES = 16,
  localparam int N_ENT = NUM_BLOCKS * BLOCK_ENTRIES,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  key_valid,
  input logic                  hit_valid,
  input logic                  hit,
  input logic [IDX_W-1:0]      hit_idx,
  input logic [NUM_BLOCKS-1:0] lkup_en,
  input logic                  busy,
  input logic [IDX_W-1:0]      cur,
  input logic [IDX_W-1:0]      cend,
  input logic [N_ENT-1:0]      vld
);
  logic [NUM_BLOCKS-1:0] en_prev;
  logic [N_ENT-1:0]      vld_prev;
  logic                  busy_prev;
  logic [IDX_W-1:0]      cur_prev, end_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev   <= '0;
      vld_prev  <= '0;
      busy_prev <= 1'b0;
      cur_prev  <= '0;
      end_prev  <= '0;
    end else begin
      en_prev   <= lkup_en;
      vld_prev  <= vld;
      busy_prev <= busy;
      cur_prev  <= cur;
      end_prev  <= cend;
    end
  end

  assert_lookup_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> hit_valid);
  assert_no_spurious_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |=> (!hit_valid && !hit));
  assert_block_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> en_prev[hit_idx / BLOCK_ENTRIES]);
  assert_hit_was_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> vld_prev[hit_idx]);
  assert_clear_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !(busy_prev && (hit_idx >= cur_prev) && (hit_idx <= end_prev)));
  assert_one_per_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cur != cend)) |=> (busy && (cur == $past(cur) + IDX_W'(1))));
  assert_end_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !vld[cend]);
endmodule

bind rule_tcam rule_tcam_chk #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_ENTRIES(BLOCK_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .hit_valid(hit_valid),
  .hit(hit), .hit_idx(hit_idx), .lkup_en(lkup_en_q), .busy(clr_busy),
  .cur(clr_cur), .cend(clr_end), .vld(vld)
);

// File: tb/tb_rule_tcam.sv
`timescale 1ns/1ps
module tb_rule_tcam;
  localparam int NB = 4;
  localparam int BE = 16;
  localparam int NE = NB * BE;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_re = 0, cfg_ctl = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [3:0] cfg_word = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic key_valid = 0;
  logic [191:0] key_words = '0;
  logic [23:0] key_fixed = '0;
  logic hit_valid, hit;
  logic [IW-1:0] hit_idx;

  always #2.5 clk = ~clk;

  rule_tcam #(.NUM_BLOCKS(NB), .BLOCK_ENTRIES(BE)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_ctl(cfg_ctl),
    .cfg_idx(cfg_idx), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .key_valid(key_valid), .key_words(key_words), .key_fixed(key_fixed),
    .hit_valid(hit_valid), .hit(hit), .hit_idx(hit_idx)
  );

  int checks = 0, failures = 0;
  logic [191:0] m_tdat [NE];
  logic [191:0] m_tmsk [NE];
  logic [23:0]  m_fdat [NE];
  logic [23:0]  m_fmsk [NE];
  logic [4:0]   m_cond [NE];
  logic [NB-1:0] m_en;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input bit ctl, input int idx, input int word, input logic [31:0] d);
    cfg_we = 1; cfg_ctl = ctl; cfg_idx = IW'(idx); cfg_word = 4'(word); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_read(input bit ctl, input int idx, input int word, output logic [31:0] d);
    cfg_re = 1; cfg_ctl = ctl; cfg_idx = IW'(idx); cfg_word = 4'(word);
    @(negedge clk);
    cfg_re = 0;
    d = cfg_rdata;
  endtask

  task automatic set_en(input logic [NB-1:0] en);
    cfg_write(1, 0, 0, 32'(en));
    m_en = en;
  endtask

  task automatic write_rule(input int e, input logic [191:0] d, input logic [191:0] m,
                            input logic [23:0] fd, input logic [23:0] fm, input logic [4:0] c);
    for (int k = 0; k < 6; k++) begin
      cfg_write(0, e, k, d[k*32 +: 32]);
      cfg_write(0, e, 7 + k, m[k*32 +: 32]);
    end
    cfg_write(0, e, 6, 32'(fd));
    cfg_write(0, e, 13, 32'(fm));
    cfg_write(0, e, 14, {c, 27'b0});
    m_tdat[e] = d; m_tmsk[e] = m; m_fdat[e] = fd; m_fmsk[e] = fm; m_cond[e] = c;
  endtask

  task automatic do_lookup(input logic [191:0] kw, input logic [23:0] kf,
                           output bit hv, output bit h, output int idx);
    key_valid = 1; key_words = kw; key_fixed = kf;
    @(negedge clk);
    key_valid = 0;
    hv = hit_valid; h = hit; idx = int'(hit_idx);
  endtask

  function automatic void model_lookup(input logic [191:0] kw, input logic [23:0] kf,
                                       output bit h, output int idx);
    h = 0; idx = 0;
    for (int e = 0; e < NE; e++) begin
      if (!h && m_cond[e][4] && m_en[e / BE] && (((kw ^ m_tdat[e]) & m_tmsk[e]) == '0) &&
          (((kf ^ m_fdat[e]) & m_fmsk[e]) == '0)) begin
        h = 1; idx = e;
      end
    end
  endfunction

  task automatic lookup_vs_model(input logic [191:0] kw, input logic [23:0] kf, input string req);
    bit hv, h, eh; int idx, eidx;
    model_lookup(kw, kf, eh, eidx);
    do_lookup(kw, kf, hv, h, idx);
    check(hv == 1, {req, " hit_valid"}, hv, 1);
    check(h == eh, {req, " hit"}, h, eh);
    if (eh) check(idx == eidx, {req, " hit_idx"}, idx, eidx);
  endtask

  function automatic logic [191:0] rnd192();
    logic [191:0] v;
    for (int k = 0; k < 6; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  bit done = 0;
  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    bit hv, h; int idx;
    logic [191:0] d, m, kw;
    logic [23:0] fd, fm, kf;
    void'($urandom(32'd1234));
    for (int e = 0; e < NE; e++) begin
      m_tdat[e] = '0; m_tmsk[e] = '0; m_fdat[e] = '0; m_fmsk[e] = '0; m_cond[e] = '0;
    end
    m_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check(hit_valid == 0 && hit == 0, "R1 outputs", {hit_valid, hit}, 0);
    cfg_read(1, 0, 0, rd); check(rd == 0, "R1 enable word", rd, 0);
    cfg_read(1, 0, 1, rd); check(rd == 0, "R1 clear word", rd, 0);

    // directed: rule 5 exact match on some bits; blocks disabled first (R4)
    d = rnd192(); m = {6{32'h0000_FFFF}};
    write_rule(5, d, m, 24'h00_0003, 24'h00_0003, 5'b10000);
    do_lookup(d, 24'h3, hv, h, idx);
    check(hv == 1 && h == 0, "R4 all blocks disabled", h, 0);
    set_en('1);
    do_lookup(d, 24'h3, hv, h, idx);
    check(hv == 1, "R6 hit_valid", hv, 1);
    check(h == 1 && idx == 5, "R2 exact match", idx, 5);
    // R2: masked-out bits do not matter, a cared bit or the tid bits do
    kw = d ^ {6{32'hFFFF_0000}};
    do_lookup(kw, 24'hFFFF_F3, hv, h, idx);
    check(h == 1 && idx == 5, "R2 don't-care bits", idx, 5);
    do_lookup(d ^ 192'h1, 24'h3, hv, h, idx);
    check(h == 0, "R2 cared data bit differs", h, 0);
    do_lookup(d, 24'h1, hv, h, idx);
    check(h == 0, "R2 tid bits differ", h, 0);
    // R5: lower index wins
    write_rule(3, d, m, 24'h3, 24'h3, 5'b10000);
    do_lookup(d, 24'h3, hv, h, idx);
    check(h == 1 && idx == 3, "R5 lowest index", idx, 3);
    // R4: block 0 disabled, rule 20 in block 1 wins
    write_rule(20, d, m, 24'h3, 24'h3, 5'b10000);
    set_en(4'b1110);
    do_lookup(d, 24'h3, hv, h, idx);
    check(h == 1 && idx == 20, "R4 block gating", idx, 20);
    // R3: invalid rule with other flags set never hits
    write_rule(20, d, m, 24'h3, 24'h3, 5'b01111);
    do_lookup(d, 24'h3, hv, h, idx);
    check(h == 0, "R3 invalid rule", h, 0);
    cfg_read(0, 20, 14, rd); check(rd == 32'h7800_0000, "R3 condition readback", rd, 32'h7800_0000);
    // R11: readback
    cfg_read(0, 5, 2, rd); check(rd == d[64 +: 32], "R11 data word", rd, d[64 +: 32]);
    cfg_read(0, 5, 9, rd); check(rd == 32'h0000_FFFF, "R11 mask word", rd, 32'h0000_FFFF);
    cfg_read(0, 5, 6, rd); check(rd == 32'h3, "R11 fixed data", rd, 3);

    // random fill and lookups (R2, R4, R5)
    for (int e = 0; e < NE; e++) begin
      m = rnd192() & rnd192() & rnd192();
      fm = 24'($urandom) & 24'($urandom) | 24'h3;
      write_rule(e, rnd192() & m, m, 24'($urandom) & fm, fm,
                 {($urandom % 4) != 0, 4'($urandom)});
    end
    for (int t = 0; t < 200; t++) begin
      if (t % 40 == 0) set_en(NB'($urandom) | NB'(1));
      begin
        int e = int'($urandom % NE);
        kw = m_tdat[e] | (rnd192() & ~m_tmsk[e]);
        kf = m_fdat[e] | (24'($urandom) & ~m_fmsk[e]);
        if (t % 5 == 4) begin kw = rnd192(); kf = 24'($urandom); end
      end
      lookup_vs_model(kw, kf, "R5 random lookup");
    end

    // R7/R8: clear rules 10..20 (11 rules)
    set_en('1);
    cfg_write(1, 0, 1, (32'd20 << 12) | (32'd10 << 1) | 32'h1);
    for (int e = 10; e <= 20; e++) m_cond[e] = '0;
    cfg_read(1, 0, 1, rd); check(rd[0] == 1, "R8 busy after command", rd[0], 1);
    repeat (9) @(negedge clk);
    cfg_read(1, 0, 1, rd); check(rd[0] == 1, "R8 busy in last cycle", rd[0], 1);
    cfg_read(1, 0, 1, rd); check(rd[0] == 0, "R8 done", rd[0], 0);
    write_rule(9, m_tdat[9], m_tmsk[9], m_fdat[9], m_fmsk[9], 5'b10000);
    write_rule(21, m_tdat[21], m_tmsk[21], m_fdat[21], m_fmsk[21], 5'b10000);
    cfg_read(0, 10, 14, rd); check(rd == 0, "R7 start cleared", rd, 0);
    cfg_read(0, 20, 14, rd); check(rd == 0, "R7 end cleared", rd, 0);
    cfg_read(0, 9, 14, rd);  check(rd[31] == 1, "R7 below range kept", rd[31], 1);
    cfg_read(0, 21, 14, rd); check(rd[31] == 1, "R7 above range kept", rd[31], 1);
    for (int t = 0; t < 40; t++) begin
      int e = int'($urandom % NE);
      lookup_vs_model(m_tdat[e], m_fdat[e], "R7 lookup after clear");
    end

    // R10: reversed range is ignored
    cfg_write(1, 0, 1, (32'd20 << 12) | (32'd30 << 1) | 32'h1);
    cfg_read(1, 0, 1, rd); check(rd[0] == 0, "R10 reversed range not started", rd[0], 0);
    write_rule(25, d, m, 24'h3, 24'h3, 5'b10000);
    cfg_read(0, 25, 14, rd); check(rd[31] == 1, "R10 rule kept", rd[31], 1);
    // R10: command while busy is ignored
    write_rule(40, d, m, 24'h3, 24'h3, 5'b10000);
    cfg_write(1, 0, 1, (32'd3 << 12) | 32'h1);
    cfg_write(1, 0, 1, (32'd40 << 12) | (32'd40 << 1) | 32'h1);
    repeat (6) @(negedge clk);
    cfg_read(0, 40, 14, rd); check(rd[31] == 1, "R10 busy command ignored", rd[31], 1);

    // R9: lookup for a still-valid rule inside the running clear window
    for (int e = 0; e < NE; e++) if (m_cond[e][4]) write_rule(e, m_tdat[e], m_tmsk[e], m_fdat[e], m_fmsk[e], 5'b0);
    write_rule(63, d, {6{32'hFFFF_FFFF}}, 24'h3, 24'hFF_FFFF, 5'b10000);
    do_lookup(d, 24'h3, hv, h, idx);
    check(h == 1 && idx == 63, "R9 hit before clear", idx, 63);
    cfg_write(1, 0, 1, (32'd63 << 12) | 32'h1);
    do_lookup(d, 24'h3, hv, h, idx);
    check(h == 0, "R9 pending rule suppressed", h, 0);
    cfg_read(0, 63, 14, rd); check(rd[31] == 1, "R9 rule still valid meanwhile", rd[31], 1);
    repeat (70) @(negedge clk);
    cfg_read(0, 63, 14, rd); check(rd == 0, "R7 full-table clear", rd, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule